// File: doc/BRIEF.md
# Multi-stream sequential line prefetcher

This unit sits beside a first-level cache and follows several independent runs of consecutive line addresses at the same time. Each run is held in its own small ring of line slots. When the cache misses, it offers the missing line address to the unit. The address is compared only with the oldest line of every run. On a match the line is handed back to the cache, that run moves forward by one line, and one more line is fetched at its far end. When no run's oldest line matches, the run that was used least recently is discarded. It is then restarted at the missing address and refilled with that line and the lines that follow it.

Prefetched lines live only in the unit's slots; the unit never writes into the cache. Fetches go to the next memory level over a valid/ready request port. That level is taken to be pipelined, so many fetches may be outstanding. Each fetch carries an identifier made of the run number (upper bits) and the slot number (lower bits). The matching reply returns that identifier, so replies may come back in any order. If a run is discarded while some of its fetches are still outstanding, those replies are dropped and the slots are fetched again for the new addresses.

Top module: `stream_prefetcher`

## Requirements
- R1: While reset is held and right after it, `miss_ready` is 1, `lk_hit` and `lk_nohit` are 0, and `req_valid` is 0 because no run is active.
- R2: A lookup that matches no run's oldest line raises `lk_nohit` for one cycle, one cycle after it is accepted. The replaced run then requests the miss address A, then A+1, A+2 and A+3, in that order.
- R3: A lookup that matches a run's oldest line whose data has arrived raises `lk_hit` one cycle after acceptance, with `lk_data` equal to that line's data. The run then makes exactly one new request, for the old oldest address plus 4.
- R4: A lookup that matches a run's oldest line whose data has not arrived holds `miss_ready` at 0 and gives no result. Once the data arrives it raises `lk_hit` with that data and returns `miss_ready` to 1.
- R5: A reply fills the slot named by `rsp_id` (upper bits run, lower bits slot), so replies returned out of order still give each line its own data.
- R6: Several runs advance independently, so lookups that alternate between them all hit with correct data.
- R7: On a no-match lookup the replaced run is the one whose last allocation or hit is the oldest. Runs used more recently keep their lines.
- R8: Replies to fetches issued before their run was replaced are discarded. The slot is fetched again, and the new lines return their own data.
- R9: Only the oldest line of a run is compared. A lookup for a later line already held in a run gives `lk_nohit`, and that run's oldest line still hits afterwards.
- R10: Each accepted lookup produces exactly one result; `lk_hit` and `lk_nohit` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Cache offers a missing line address |
| miss_addr | input | ADDR_W | Missing line address |
| miss_ready | output | 1 | Unit can accept a lookup this cycle |
| lk_hit | output | 1 | One-cycle pulse: line supplied on lk_data |
| lk_nohit | output | 1 | One-cycle pulse: no run held the line, a run was restarted |
| lk_data | output | DATA_W | Data of the supplied line |
| req_valid | output | 1 | Fetch request to next level |
| req_ready | input | 1 | Next level accepts the request this cycle |
| req_addr | output | ADDR_W | Line address to fetch |
| req_id | output | log2(NUM_STREAMS)+log2(DEPTH) | Run and slot identifier of the fetch |
| rsp_valid | input | 1 | Reply from next level |
| rsp_id | input | log2(NUM_STREAMS)+log2(DEPTH) | Identifier copied from the request |
| rsp_data | input | DATA_W | Line data of the reply |

## Verification
The assertions assume that the next level sends exactly one reply for every accepted request, and only for identifiers that are still outstanding. They also assume that the cache offers lookups only while `miss_ready` is 1. The bench's memory model enforces this. It records each request that is accepted under `req_ready` (which it drops every third cycle) and answers from that record once, in order or newest-first. The lookup driver waits for `miss_ready` before raising `miss_valid`. Replies are switched off for long stretches to build up outstanding fetches, stalls and replaced runs with fetches still in flight.

// File: rtl/pf_pkg.sv
// Shared types for the sequential line prefetcher.
package pf_pkg;
    // Per-slot flags: request issued, reply outstanding, outstanding reply is stale, data present.
    typedef struct packed {
        logic sent;
        logic busy;
        logic stale;
        logic arrived;
    } pf_slot_t;

    // Lookup controller state.
    typedef enum logic {
        LK_IDLE,
        LK_WAIT
    } pf_lk_t;
endpackage

// File: rtl/pf_lru.sv
// Recency ranking over the runs. Rank 0 is most recent and NUM-1 is the victim.
// Assumes NUM >= 2. Reset ranks equal the run index, so run NUM-1 is replaced first.
module pf_lru #(
    parameter int NUM = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   touch_i,
    input  logic [$clog2(NUM)-1:0] touch_idx_i,
    output logic [$clog2(NUM)-1:0] victim_o
);
    localparam int IW = $clog2(NUM);

    logic [IW-1:0] rank [NUM];

    // Move the touched run to rank 0 and age the runs that were more recent than it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) rank[i] <= IW'(i);
        end else if (touch_i) begin
            for (int i = 0; i < NUM; i++) begin
                if (IW'(i) == touch_idx_i)          rank[i] <= '0;
                else if (rank[i] < rank[touch_idx_i]) rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    // Pick the run holding the oldest rank.
    always_comb begin
        victim_o = '0;
        for (int i = 0; i < NUM; i++)
            if (rank[i] == IW'(NUM - 1)) victim_o = IW'(i);
    end

    // R7: a run just touched is never the next victim.
    p_touched_not_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> victim_o != $past(touch_idx_i));
endmodule

// File: rtl/pf_stream.sv
// One run: a ring of DEPTH slots holding lines base, base+1, ... base+DEPTH-1.
// Slot tags are derived from base and the head pointer, so no per-slot tag is stored.
// A slot with an outstanding reply is never reissued. A flush marks it stale so that its
// reply is dropped. Assumes DEPTH is a power of two and replies come only for busy slots.
module pf_stream
    import pf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic [ADDR_W-1:0]        flush_addr_i,
    input  logic                     pop_i,
    input  logic                     grant_i,
    input  logic                     rsp_i,
    input  logic [$clog2(DEPTH)-1:0] rsp_slot_i,
    input  logic [DATA_W-1:0]        rsp_data_i,
    output logic                     live_o,
    output logic [ADDR_W-1:0]        head_addr_o,
    output logic                     head_ready_o,
    output logic [DATA_W-1:0]        head_data_o,
    output logic                     want_o,
    output logic [$clog2(DEPTH)-1:0] want_slot_o,
    output logic [ADDR_W-1:0]        want_addr_o
);
    localparam int SW = $clog2(DEPTH);

    logic              live_q, live_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [SW-1:0]     head_q, head_d;
    pf_slot_t          flag_q [DEPTH];
    pf_slot_t          flag_d [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DATA_W-1:0] data_d [DEPTH];
    logic [SW-1:0]     ring   [DEPTH];

    assign live_o       = live_q;
    assign head_addr_o  = base_q;
    assign head_ready_o = flag_q[head_q].arrived;
    assign head_data_o  = data_q[head_q];

    // Slot index of each ring position, position 0 being the head.
    always_comb begin
        for (int k = 0; k < DEPTH; k++) ring[k] = head_q + SW'(k);
    end

    // Request the free slot closest to the head, so lines go out in address order.
    always_comb begin
        want_o      = 1'b0;
        want_slot_o = '0;
        want_addr_o = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (live_q && !flag_q[ring[k]].sent && !flag_q[ring[k]].busy) begin
                want_o      = 1'b1;
                want_slot_o = ring[k];
                want_addr_o = base_q + ADDR_W'(k);
            end
        end
    end

    // Next state: reply, then issue, then flush or pop, in that order of precedence.
    always_comb begin
        live_d = live_q;
        base_d = base_q;
        head_d = head_q;
        flag_d = flag_q;
        data_d = data_q;
        if (rsp_i) begin
            flag_d[rsp_slot_i].busy = 1'b0;
            if (!flag_q[rsp_slot_i].stale) begin
                flag_d[rsp_slot_i].arrived = 1'b1;
                data_d[rsp_slot_i]         = rsp_data_i;
            end
            flag_d[rsp_slot_i].stale = 1'b0;
        end
        if (grant_i) begin
            flag_d[want_slot_o].sent = 1'b1;
            flag_d[want_slot_o].busy = 1'b1;
        end
        if (flush_i) begin
            live_d = 1'b1;
            base_d = flush_addr_i;
            head_d = '0;
            for (int j = 0; j < DEPTH; j++) begin
                flag_d[j].stale   = flag_d[j].busy;
                flag_d[j].sent    = 1'b0;
                flag_d[j].arrived = 1'b0;
            end
        end else if (pop_i) begin
            flag_d[head_q].sent    = 1'b0;
            flag_d[head_q].arrived = 1'b0;
            base_d                 = base_q + 1'b1;
            head_d                 = head_q + 1'b1;
        end
    end

    // Control state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            base_q <= '0;
            head_q <= '0;
            for (int j = 0; j < DEPTH; j++) flag_q[j] <= '0;
        end else begin
            live_q <= live_d;
            base_q <= base_d;
            head_q <= head_d;
            flag_q <= flag_d;
        end
    end

    // Line data storage, qualified by the arrived flags.
    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    // R4: the controller pops only a head whose data is present.
    p_pop_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> head_ready_o);

    // R5: a reply always targets a slot with an outstanding request.
    p_rsp_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_i |-> flag_q[rsp_slot_i].busy);

    // R3: a pop without a flush moves the head address forward by one line.
    p_pop_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !flush_i) |=> head_addr_o == $past(head_addr_o) + 1'b1);
endmodule

// File: rtl/stream_prefetcher.sv
// Multi-stream sequential prefetcher top. It holds NUM_STREAMS runs, compares every run's
// oldest line with each cache miss, pops on a match, and restarts the least recently used
// run when nothing matches. Fetches are arbitrated by fixed priority (lowest run first).
// Assumes the next level answers each accepted request once, with the request identifier.
module stream_prefetcher
    import pf_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int DEPTH       = 4,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            miss_valid,
    input  logic [ADDR_W-1:0]                               miss_addr,
    output logic                                            miss_ready,
    output logic                                            lk_hit,
    output logic                                            lk_nohit,
    output logic [DATA_W-1:0]                               lk_data,
    output logic                                            req_valid,
    input  logic                                            req_ready,
    output logic [ADDR_W-1:0]                               req_addr,
    output logic [$clog2(NUM_STREAMS)+$clog2(DEPTH)-1:0]    req_id,
    input  logic                                            rsp_valid,
    input  logic [$clog2(NUM_STREAMS)+$clog2(DEPTH)-1:0]    rsp_id,
    input  logic [DATA_W-1:0]                               rsp_data
);
    localparam int SW   = $clog2(NUM_STREAMS);
    localparam int LW   = $clog2(DEPTH);
    localparam int ID_W = SW + LW;

    logic [NUM_STREAMS-1:0] live, head_ready, want, flush, pop, grant, rsp_hit;
    logic [ADDR_W-1:0]      head_addr [NUM_STREAMS];
    logic [DATA_W-1:0]      head_data [NUM_STREAMS];
    logic [LW-1:0]          want_slot [NUM_STREAMS];
    logic [ADDR_W-1:0]      want_addr [NUM_STREAMS];

    pf_lk_t        state_q;
    logic [SW-1:0] wait_idx_q;
    logic [SW-1:0] sel, match_idx, victim;
    logic          match_any, accept;

    assign miss_ready = (state_q == LK_IDLE);
    assign accept     = miss_valid && miss_ready;

    // Fixed-priority pick of the run whose fetch goes out.
    always_comb begin
        sel       = '0;
        req_valid = 1'b0;
        for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
            if (want[i]) begin
                sel       = SW'(i);
                req_valid = 1'b1;
            end
        end
    end

    assign req_addr = want_addr[sel];
    assign req_id   = {sel, want_slot[sel]};

    // Compare the miss address with every live run's oldest line; lowest index wins.
    always_comb begin
        match_any = 1'b0;
        match_idx = '0;
        for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
            if (live[i] && head_addr[i] == miss_addr) begin
                match_any = 1'b1;
                match_idx = SW'(i);
            end
        end
    end

    pf_lru #(.NUM(NUM_STREAMS)) i_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_i     (accept),
        .touch_idx_i (match_any ? match_idx : victim),
        .victim_o    (victim)
    );

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_run
        assign rsp_hit[g] = rsp_valid && (rsp_id[ID_W-1:LW] == SW'(g));
        assign grant[g]   = req_valid && req_ready && (sel == SW'(g));
        assign flush[g]   = accept && !match_any && (victim == SW'(g));
        assign pop[g]     = head_ready[g] &&
                            ((accept && match_any && match_idx == SW'(g)) ||
                             (state_q == LK_WAIT && wait_idx_q == SW'(g)));

        pf_stream #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_stream (
            .clk          (clk),
            .rst_n        (rst_n),
            .flush_i      (flush[g]),
            .flush_addr_i (miss_addr),
            .pop_i        (pop[g]),
            .grant_i      (grant[g]),
            .rsp_i        (rsp_hit[g]),
            .rsp_slot_i   (rsp_id[LW-1:0]),
            .rsp_data_i   (rsp_data),
            .live_o       (live[g]),
            .head_addr_o  (head_addr[g]),
            .head_ready_o (head_ready[g]),
            .head_data_o  (head_data[g]),
            .want_o       (want[g]),
            .want_slot_o  (want_slot[g]),
            .want_addr_o  (want_addr[g])
        );
    end

    // Lookup controller: answer at once, or wait on a matched head whose data is missing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LK_IDLE;
            wait_idx_q <= '0;
            lk_hit     <= 1'b0;
            lk_nohit   <= 1'b0;
            lk_data    <= '0;
        end else begin
            lk_hit   <= 1'b0;
            lk_nohit <= 1'b0;
            case (state_q)
                LK_IDLE: begin
                    if (accept) begin
                        if (!match_any) begin
                            lk_nohit <= 1'b1;
                        end else if (head_ready[match_idx]) begin
                            lk_hit  <= 1'b1;
                            lk_data <= head_data[match_idx];
                        end else begin
                            state_q    <= LK_WAIT;
                            wait_idx_q <= match_idx;
                        end
                    end
                end
                default: begin
                    if (head_ready[wait_idx_q]) begin
                        lk_hit  <= 1'b1;
                        lk_data <= head_data[wait_idx_q];
                        state_q <= LK_IDLE;
                    end
                end
            endcase
        end
    end

    // R10: the two result pulses never coincide.
    p_single_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_nohit));

    // R10: an accepted lookup is answered next cycle or turns into a stall.
    p_lookup_answered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> (lk_hit || lk_nohit || !miss_ready));

    // R4: a stall ends only together with a hit.
    p_stall_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_ready |=> (!miss_ready || lk_hit));

    // R2: a no-match result leaves at least one run live that can fetch.
    p_nohit_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_nohit |-> (live != '0));
endmodule

// File: tb/test_stream_prefetcher.sv
// Scoreboard bench: the lookup driver queues expected results, a monitor pops and compares.
module test_stream_prefetcher;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n, miss_valid, miss_ready, lk_hit, lk_nohit;
    logic [AW-1:0] miss_addr, req_addr;
    logic [DW-1:0] lk_data, rsp_data;
    logic          req_valid, req_ready, rsp_valid;
    logic [IW-1:0] req_id, rsp_id;

    int errors = 0;
    int checks = 0;
    bit rsp_on = 1'b1;
    bit rsp_rev = 1'b0;
    int cyc = 0;

    logic [AW-1:0] pend_addr[$];
    logic [IW-1:0] pend_id[$];
    logic [AW-1:0] req_log[$];
    bit            exp_hit[$];
    logic [DW-1:0] exp_data[$];
    string         exp_tag[$];

    always #10 clk = ~clk;

    stream_prefetcher i_stream_prefetcher (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_ready(miss_ready), .lk_hit(lk_hit), .lk_nohit(lk_nohit), .lk_data(lk_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_id(req_id),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data)
    );

    function automatic logic [DW-1:0] line_data(logic [AW-1:0] a);
        return {a ^ 16'hA5A5, a};
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: offer one lookup when ready and queue the expected result.
    task automatic lookup(logic [AW-1:0] a, bit hit, string tag, bit prompt);
        while (!miss_ready) @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        exp_hit.push_back(hit);
        exp_data.push_back(hit ? line_data(a) : '0);
        exp_tag.push_back(tag);
        @(negedge clk);
        miss_valid = 1'b0;
        if (prompt) check(lk_hit || lk_nohit, tag, "result one cycle after accept",
                          {30'd0, lk_hit, lk_nohit}, 32'd1);
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 2000 && exp_hit.size() > 0; i++) @(negedge clk);
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && (lk_hit || lk_nohit)) begin
            check(!(lk_hit && lk_nohit), "R10", "both result pulses", {30'd0, lk_hit, lk_nohit}, 32'd0);
            if (exp_hit.size() == 0) begin
                check(1'b0, "R10", "unexpected result", {31'd0, lk_hit}, 32'd0);
            end else begin
                automatic bit          eh = exp_hit.pop_front();
                automatic logic [DW-1:0] ed = exp_data.pop_front();
                automatic string       et = exp_tag.pop_front();
                check(lk_hit == eh, et, "hit flag", {31'd0, lk_hit}, {31'd0, eh});
                if (eh) check(lk_data == ed, et, "line data", lk_data, ed);
            end
        end
    end

    // Next-level memory model: ready every two of three cycles, one reply per request.
    initial begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_id    = '0;
        rsp_data  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            rsp_valid = 1'b0;
            if (rst_n && rsp_on && pend_addr.size() > 0) begin
                automatic logic [AW-1:0] a;
                automatic logic [IW-1:0] id;
                if (rsp_rev) begin
                    a  = pend_addr.pop_back();
                    id = pend_id.pop_back();
                end else begin
                    a  = pend_addr.pop_front();
                    id = pend_id.pop_front();
                end
                rsp_valid = 1'b1;
                rsp_id    = id;
                rsp_data  = line_data(a);
            end
            req_ready = rst_n && (cyc % 3 != 0);
            #1;
            if (req_valid && req_ready) begin
                pend_addr.push_back(req_addr);
                pend_id.push_back(req_id);
                req_log.push_back(req_addr);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: pending results %0d expected 0", exp_hit.size());
        summary();
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        miss_valid = 1'b0;
        miss_addr  = '0;
        wait_clks(4);
        check(miss_ready == 1'b1, "R1", "miss_ready in reset", {31'd0, miss_ready}, 32'd1);
        check(!lk_hit && !lk_nohit, "R1", "results in reset", {30'd0, lk_hit, lk_nohit}, 32'd0);
        check(req_valid == 1'b0, "R1", "req_valid in reset", {31'd0, req_valid}, 32'd0);
        rst_n = 1'b1;
        wait_clks(3);
        check(req_valid == 1'b0 && miss_ready, "R1", "idle after reset",
              {30'd0, req_valid, miss_ready}, 32'd1);

        // R2: restart at the miss address, four consecutive requests in order.
        req_log.delete();
        lookup(16'h0100, 1'b0, "R2", 1'b1);
        wait_clks(30);
        check(req_log.size() == 4, "R2", "request count", req_log.size(), 32'd4);
        for (int i = 0; i < 4 && i < req_log.size(); i++)
            check(req_log[i] == 16'h0100 + AW'(i), "R2", "request order", req_log[i], 16'h0100 + AW'(i));

        // R3: head hit returns data and refills exactly one line at base+4.
        req_log.delete();
        lookup(16'h0100, 1'b1, "R3", 1'b1);
        wait_clks(30);
        check(req_log.size() == 1, "R3", "refill count", req_log.size(), 32'd1);
        if (req_log.size() > 0) check(req_log[0] == 16'h0104, "R3", "refill address", req_log[0], 32'h0104);
        lookup(16'h0101, 1'b1, "R3", 1'b1);
        lookup(16'h0102, 1'b1, "R3", 1'b0);

        // R6: two more runs, lookups alternate across three runs.
        lookup(16'h0200, 1'b0, "R6", 1'b1);
        lookup(16'h0300, 1'b0, "R6", 1'b1);
        wait_clks(40);
        lookup(16'h0200, 1'b1, "R6", 1'b0);
        lookup(16'h0300, 1'b1, "R6", 1'b0);
        lookup(16'h0201, 1'b1, "R6", 1'b0);
        lookup(16'h0301, 1'b1, "R6", 1'b0);
        lookup(16'h0103, 1'b1, "R6", 1'b0);
        wait_empty();

        // R7: fourth run fills the free one, fifth replaces the run headed at 0x202.
        lookup(16'h0400, 1'b0, "R7", 1'b1);
        lookup(16'h0500, 1'b0, "R7", 1'b1);
        wait_clks(40);
        lookup(16'h0104, 1'b1, "R7", 1'b0);
        lookup(16'h0400, 1'b1, "R7", 1'b0);
        lookup(16'h0500, 1'b1, "R7", 1'b0);
        lookup(16'h0302, 1'b1, "R7", 1'b0);
        lookup(16'h0202, 1'b0, "R7", 1'b1);
        wait_empty();
        wait_clks(40);

        // R4: hit on a head whose data is held back stalls, then returns the data.
        rsp_on = 1'b0;
        lookup(16'h0600, 1'b0, "R4", 1'b1);
        wait_clks(10);
        lookup(16'h0600, 1'b1, "R4", 1'b0);
        check(miss_ready == 1'b0, "R4", "stall begins", {31'd0, miss_ready}, 32'd0);
        wait_clks(5);
        check(miss_ready == 1'b0 && exp_hit.size() == 1, "R4", "still stalled",
              {31'd0, miss_ready}, 32'd0);
        rsp_on = 1'b1;
        wait_empty();
        check(exp_hit.size() == 0 && miss_ready, "R4", "stall released", exp_hit.size(), 32'd0);
        wait_clks(40);

        // R5: replies returned newest first still fill their own slots.
        rsp_on = 1'b0;
        lookup(16'h0700, 1'b0, "R5", 1'b1);
        wait_clks(20);
        rsp_rev = 1'b1;
        rsp_on  = 1'b1;
        wait_clks(40);
        rsp_rev = 1'b0;
        for (int i = 0; i < 4; i++) lookup(16'h0700 + AW'(i), 1'b1, "R5", 1'b0);
        wait_empty();
        wait_clks(40);

        // R8: run replaced while its fetches are outstanding drops the stale replies.
        rsp_on = 1'b0;
        lookup(16'h0800, 1'b0, "R8", 1'b1);
        wait_clks(10);
        lookup(16'h0900, 1'b0, "R8", 1'b1);
        lookup(16'h0A00, 1'b0, "R8", 1'b1);
        lookup(16'h0B00, 1'b0, "R8", 1'b1);
        lookup(16'h0C00, 1'b0, "R8", 1'b1);
        wait_clks(10);
        rsp_on = 1'b1;
        wait_clks(60);
        for (int i = 0; i < 4; i++) lookup(16'h0C00 + AW'(i), 1'b1, "R8", 1'b0);
        lookup(16'h0900, 1'b1, "R8", 1'b0);
        wait_empty();
        wait_clks(40);

        // R9: a later line of a run is not matched; the run's head still hits.
        lookup(16'h0C05, 1'b0, "R9", 1'b1);
        lookup(16'h0C04, 1'b1, "R9", 1'b0);
        wait_empty();

        wait_clks(10);
        check(exp_hit.size() == 0, "R10", "all lookups answered", exp_hit.size(), 32'd0);
        summary();
        $finish;
    end
endmodule